// File: doc/BRIEF.md
# Toggle-Handshake Falling-Edge Word RAM Driver

This block wraps a single-port array of 32-bit words so that a rising-edge controller can load and store words without touching the array itself. The controller places a byte address, a write-select bit and a write word on its request lines and then inverts a request toggle flag. A separate access block, clocked on the falling edge, is the only logic that reads or writes the array, which keeps the array in a shape that block-RAM inference recognises. It serves a request whenever its acknowledge flag differs from the request flag, and then copies the request flag into the acknowledge flag.

A store issued on one rising edge is complete by the next rising edge. A load issued on one rising edge has its word registered on the falling edge that follows, and the controller consumes it one state later. Byte addresses are aligned to four. The word index is the byte address minus a base offset, divided by four.

A small demonstration controller exercises the driver. It has a next-state process and a datapath process that share one state register. After a start pulse it stores `base_val + i` at word `i` for `i = 0 .. n-1`. It then re-reads every word, one load and one wait state each, and raises `finish` with the 32-bit sum of the words it read on `result`.

Top module: `toggle_ram_engine`

## Requirements
- R1: Synchronous active-high reset drives `finish` low, `result` to 0, and both handshake flags to 0, so no access is pending. A reset in the middle of a run abandons that run, and the next start runs normally. Memory contents are not cleared.
- R2: Element `i` of a run is stored at byte address `BASE_ADDR + 4*i`, which maps to word index `i`, with value `base_val + i` (mod 2^32). `base_val` and `count` are captured on the rising edge that samples `start`.
- R3: `result` equals the 32-bit wrapping sum of the `n` words read back, that is `n*base_val + n*(n-1)/2` mod 2^32.
- R4: Each store takes one rising-edge cycle and each load takes two (issue, then a wait state that consumes the read word). For `n >= 1`, `finish` is first high after the 3n-th rising edge that follows the edge sampling `start`.
- R5: A `count` of 0 produces `finish` high with `result` 0 right after the edge that samples `start`.
- R6: A `count` above `DEPTH` is clamped to `DEPTH`.
- R7: `start`, `base_val` and `count` are ignored while a run is in progress.
- R8: `finish` and `result` hold their values while idle until the next accepted `start`. For a non-empty run, that `start` clears `finish` on the same edge.
- R9: The access block acts only when the acknowledge and request flags differ. Only a store or load state toggles the request flag, and each request is resolved before the next rising edge.
- R10: Every request carries an aligned byte address inside `[BASE_ADDR, BASE_ADDR + 4*DEPTH)`.
- R11: A later run with a different `base_val` overwrites the earlier contents, and its reads return only the new words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The controller uses the rising edge and the RAM access block the falling edge. |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a run when the controller is idle |
| base_val | input | 32 | Value of element 0. Element `i` holds `base_val + i`. |
| count | input | $clog2(DEPTH+1) | Number of elements, clamped to DEPTH |
| finish | output | 1 | High once a run has completed |
| result | output | 32 | Wrapping sum of the words read back |

## Verification
Runs of length 1, 4 and full depth, with small base values and with a base near 2^32, separate correct address mapping and wrapping addition from stuck or shifted words. Zero-length and over-length counts probe the empty-run shortcut and the clamp. A second start pulse during a run, carrying a different base and count, shows whether busy-time inputs leak in. A rerun with a new base over the same words shows whether stores really land. The cycle distance from start to finish is measured on every run, which separates a missing wait state or an extra stall from a correct one-cycle store and two-cycle load.

// File: rtl/tgram_pkg.sv
`timescale 1ns/1ps
package tgram_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_STORE     = 2'd1,
    ST_LOAD      = 2'd2,
    ST_LOAD_WAIT = 2'd3
  } ctl_state_t;
endpackage

// File: rtl/tgram_word_store.sv
`timescale 1ns/1ps
// Falling-edge access block: sole owner of the word array.
module tgram_word_store
  import tgram_pkg::*;
#(
  parameter int             DEPTH     = 32,
  parameter int             AW        = 16,
  parameter logic [AW-1:0]  BASE_ADDR = 16'h0400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_tgl,
  input  logic [AW-1:0]     addr,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output logic              ack_tgl,
  output logic [WORD_W-1:0] rdata
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     offs;
  logic [IDX_W-1:0]  widx;
  logic              pend;
  logic              unused_offs_bits;

  // strip the base, drop the two byte-lane bits
  assign offs             = addr - BASE_ADDR;
  assign widx             = offs[IDX_W+1:2];
  assign unused_offs_bits = ^{offs[AW-1:IDX_W+2], offs[1:0]};
  assign pend             = (req_tgl != ack_tgl);

  always_ff @(negedge clk) begin
    if (!rst && pend && we)
      mem[widx] <= wdata;
  end

  always_ff @(negedge clk) begin
    if (!rst && pend && !we)
      rdata <= mem[widx];
  end

  always_ff @(negedge clk) begin
    if (rst)       ack_tgl <= 1'b0;
    else if (pend) ack_tgl <= req_tgl;
  end
endmodule

// File: rtl/tgram_ctl_next.sv
`timescale 1ns/1ps
// Control half of the demonstration machine: next-state only.
module tgram_ctl_next
  import tgram_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       cnt_zero,
  input  logic       last,
  output ctl_state_t state
);
  ctl_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:      if (start && !cnt_zero) nxt = ST_STORE;
      ST_STORE:     if (last) nxt = ST_LOAD;
      ST_LOAD:      nxt = ST_LOAD_WAIT;
      ST_LOAD_WAIT: nxt = last ? ST_IDLE : ST_LOAD;
      default:      nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/tgram_ctl_path.sv
`timescale 1ns/1ps
// Datapath half: indexed by the same state, drives the request lines.
module tgram_ctl_path
  import tgram_pkg::*;
#(
  parameter int             DEPTH     = 32,
  parameter int             AW        = 16,
  parameter logic [AW-1:0]  BASE_ADDR = 16'h0400,
  parameter int             CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_state_t        state,
  input  logic              start,
  input  logic [WORD_W-1:0] base_val,
  input  logic [CNT_W-1:0]  cnt_eff,
  input  logic [WORD_W-1:0] rdata,
  output logic              last,
  output logic              req_tgl,
  output logic [AW-1:0]     addr,
  output logic              we,
  output logic [WORD_W-1:0] wdata,
  output logic              finish,
  output logic [WORD_W-1:0] result
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  n_lat;
  logic [WORD_W-1:0] base_lat;
  logic [WORD_W-1:0] sum;

  assign last = (CNT_W'(idx) == n_lat - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      n_lat    <= '0;
      base_lat <= '0;
      sum      <= '0;
      req_tgl  <= 1'b0;
      addr     <= BASE_ADDR;
      we       <= 1'b0;
      wdata    <= '0;
      finish   <= 1'b0;
      result   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            n_lat    <= cnt_eff;
            base_lat <= base_val;
            idx      <= '0;
            sum      <= '0;
            if (cnt_eff == '0) begin
              finish <= 1'b1;
              result <= '0;
            end else begin
              finish <= 1'b0;
            end
          end
        end
        ST_STORE: begin
          addr    <= BASE_ADDR + AW'({idx, 2'b00});
          we      <= 1'b1;
          wdata   <= base_lat + WORD_W'(idx);
          req_tgl <= ~req_tgl;
          idx     <= last ? '0 : idx + IDX_W'(1);
        end
        ST_LOAD: begin
          addr    <= BASE_ADDR + AW'({idx, 2'b00});
          we      <= 1'b0;
          req_tgl <= ~req_tgl;
        end
        ST_LOAD_WAIT: begin
          sum <= sum + rdata;
          if (last) begin
            finish <= 1'b1;
            result <= sum + rdata;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/toggle_ram_engine.sv
`timescale 1ns/1ps
module toggle_ram_engine
  import tgram_pkg::*;
#(
  parameter int             DEPTH     = 32,
  parameter int             AW        = 16,
  parameter logic [AW-1:0]  BASE_ADDR = 16'h0400,
  parameter int             CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] base_val,
  input  logic [CNT_W-1:0]  count,
  output logic              finish,
  output logic [WORD_W-1:0] result
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  ctl_state_t        state;
  logic [CNT_W-1:0]  cnt_eff;
  logic              last;
  logic              req_tgl;
  logic              ack_tgl;
  logic [AW-1:0]     ram_addr;
  logic              ram_we;
  logic [WORD_W-1:0] ram_wdata;
  logic [WORD_W-1:0] ram_rdata;

  assign cnt_eff = (count > DEPTH_C) ? DEPTH_C : count;

  tgram_ctl_next u_next (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cnt_zero (cnt_eff == '0),
    .last     (last),
    .state    (state)
  );

  tgram_ctl_path #(
    .DEPTH(DEPTH), .AW(AW), .BASE_ADDR(BASE_ADDR), .CNT_W(CNT_W)
  ) u_path (
    .clk      (clk),
    .rst      (rst),
    .state    (state),
    .start    (start),
    .base_val (base_val),
    .cnt_eff  (cnt_eff),
    .rdata    (ram_rdata),
    .last     (last),
    .req_tgl  (req_tgl),
    .addr     (ram_addr),
    .we       (ram_we),
    .wdata    (ram_wdata),
    .finish   (finish),
    .result   (result)
  );

  tgram_word_store #(
    .DEPTH(DEPTH), .AW(AW), .BASE_ADDR(BASE_ADDR)
  ) u_ram (
    .clk     (clk),
    .rst     (rst),
    .req_tgl (req_tgl),
    .addr    (ram_addr),
    .we      (ram_we),
    .wdata   (ram_wdata),
    .ack_tgl (ack_tgl),
    .rdata   (ram_rdata)
  );
endmodule

// File: rtl/toggle_ram_engine_chk.sv
`timescale 1ns/1ps
module toggle_ram_engine_chk
  import tgram_pkg::*;
#(
  parameter int             DEPTH     = 32,
  parameter int             AW        = 16,
  parameter logic [AW-1:0]  BASE_ADDR = 16'h0400
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              finish,
  input logic [WORD_W-1:0] result,
  input ctl_state_t        state,
  input logic              req_tgl,
  input logic              ack_tgl,
  input logic [AW-1:0]     ram_addr
);
  localparam logic [AW:0] LO_A = {1'b0, BASE_ADDR};
  localparam logic [AW:0] HI_A = LO_A + (AW+1)'(4 * DEPTH);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: state right after a reset edge
  always @(negedge clk) begin
    if (rst_q === 1'b1)
      assert_reset_state_R1: assert (!finish && result == '0 && !req_tgl);
  end

  // R9: every request is resolved before the next rising edge
  assert_flags_settle_R9: assert property (@(posedge clk) disable iff (rst)
    ack_tgl == req_tgl);

  // R9: only access states toggle the request flag
  assert_req_from_access_state_R9: assert property (@(posedge clk) disable iff (rst)
    (req_tgl != $past(req_tgl)) |->
      ($past(state) == ST_STORE || $past(state) == ST_LOAD));

  // R10: aligned, in-range byte address on every request
  assert_addr_aligned_R10: assert property (@(posedge clk) disable iff (rst)
    (req_tgl != $past(req_tgl)) |->
      (ram_addr[1:0] == 2'b00 && {1'b0, ram_addr} >= LO_A && {1'b0, ram_addr} < HI_A));

  // R4: a load is always followed by its wait state
  assert_load_wait_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD) |=> (state == ST_LOAD_WAIT));

  // R8: idle finish and result hold without start
  assert_finish_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (finish && state == ST_IDLE && !start) |=> (finish && $stable(result)));
endmodule

bind toggle_ram_engine toggle_ram_engine_chk #(
  .DEPTH(DEPTH), .AW(AW), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .finish   (finish),
  .result   (result),
  .state    (state),
  .req_tgl  (req_tgl),
  .ack_tgl  (ack_tgl),
  .ram_addr (ram_addr)
);

// File: tb/test_toggle_ram_engine.sv
`timescale 1ns/1ps
module test_toggle_ram_engine;
  localparam int DEPTH = 32;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [31:0]      base_val = '0;
  logic [CNT_W-1:0] count = '0;
  logic             finish;
  logic [31:0]      result;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_edge = 0;
  bit armed = 1'b0;

  typedef struct { logic [31:0] res; int lat; string tag; } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  toggle_ram_engine #(.DEPTH(DEPTH)) i_toggle_ram_engine (
    .clk(clk), .rst(rst), .start(start), .base_val(base_val),
    .count(count), .finish(finish), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_sum(input logic [31:0] b, input int n);
    logic [31:0] s = '0;
    for (int i = 0; i < n; i++) s = s + b + 32'(i);
    return s;
  endfunction

  // monitor: pops the expected item at completion
  always @(negedge clk) begin
    if (armed && cyc >= exp_edge && finish === 1'b1) begin
      exp_t it;
      it = sb_q.pop_front();
      chk(result === it.res, {it.tag, " result"}, result, it.res);
      chk(cyc - exp_edge == it.lat, {it.tag, " latency R4 R9"}, cyc - exp_edge, it.lat);
      armed = 1'b0;
    end
  end

  // driver: push expectation, pulse start, optionally poke while busy
  task automatic run(input logic [31:0] b, input int c, input bit poke, input string tag);
    exp_t it;
    int n;
    n = (c > DEPTH) ? DEPTH : c;
    it.res = exp_sum(b, n);
    it.lat = 3 * n;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    base_val = b;
    count    = CNT_W'(c);
    start    = 1'b1;
    exp_edge = cyc + 1;
    armed    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      base_val = ~b;
      count    = CNT_W'(5);
      start    = 1'b1;
      @(negedge clk);
      start    = 1'b0;
    end
    while (armed) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    chk(finish === 1'b0, "R1 finish in reset", finish, 0);
    chk(result === 32'h0, "R1 result in reset", result, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(finish === 1'b0, "R1 finish idle after reset", finish, 0);

    run(32'h0000_0100, 4, 1'b0, "R2 R3 n=4");
    run(32'h0000_0000, 1, 1'b0, "R2 R3 n=1");
    run(32'hFFFF_FFF0, DEPTH, 1'b0, "R3 R10 wrap full depth");
    run(32'h1234_5678, 0, 1'b0, "R5 empty run");
    run(32'h0000_0007, 45, 1'b0, "R6 clamp");
    run(32'hA5A5_0000, 6, 1'b1, "R7 busy start ignored");

    held = result;
    repeat (6) @(negedge clk);
    chk(finish === 1'b1, "R8 finish held", finish, 1);
    chk(result === held, "R8 result held", result, held);

    run(32'h0000_1000, 8, 1'b0, "R11 first fill");
    run(32'h0BAD_0000, 8, 1'b0, "R11 overwrite");
    run(32'h0000_0003, 0, 1'b0, "R5 R8 empty after finish");

    // reset in the middle of a run
    @(negedge clk);
    base_val = 32'h55;
    count    = CNT_W'(10);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(finish === 1'b0, "R8 start clears finish", finish, 0);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(finish === 1'b0, "R1 finish after mid-run reset", finish, 0);
    chk(result === 32'h0, "R1 result after mid-run reset", result, 0);
    rst = 1'b0;
    @(negedge clk);
    run(32'h0000_0020, 5, 1'b0, "R1 R9 rerun after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule